// File: doc/BRIEF.md
# Eight-Lane Unsigned Merge Sorter

This block takes eight unsigned words and puts them in ascending order, one word per output lane. The sorting logic has no state and no control. It is a fixed web of two-input compare-exchange cells wired in the recursive odd/even merge pattern. Each half of the input is sorted, the halves are merged, and this is repeated down to pairs. The network uses 19 cells spread over six levels.

Words that skip a level travel on plain wires, so lanes see different logic depths. The shortest path crosses three cells and the longest crosses six. The network output goes through an optional register bank, selected by a parameter, so the block can sit in a timed pipeline. With the bank in place, the result for the word set present at a rising edge appears just after that edge.

Lane i of the packed buses occupies bits [i*WIDTH +: WIDTH]. Lane 0 holds the smallest output.

Top module: `oem_sort8`

## Requirements
- R1: The output lanes are in non-decreasing order: lane i is less than or equal to lane i+1 for i = 0..6.
- R2: The output is a permutation of the input. Every input value appears as many times at the output as at the input, including repeated values.
- R3: Values are compared as unsigned WIDTH-bit integers, so a word with its top bit set ranks above every word whose top bit is clear.
- R4: With the register stage enabled (OUT_STAGE=1), `dout` shows the sorted form of the `din` sampled at the most recent rising edge of `clk`. It does not change between edges, even when `din` changes.
- R5: While `rst_n` is low, every output lane is zero.
- R6: An input that is already in ascending order comes out unchanged, lane for lane.
- R7: Output lane 0 equals the minimum of the eight inputs and output lane 7 equals their maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| din | input | 8*WIDTH | Eight unsorted words, lane i at bits [i*WIDTH +: WIDTH] |
| dout | output | 8*WIDTH | Eight sorted words, smallest in lane 0 |

## Verification
The block holds no internal state apart from the output bank, so a miswired or inverted cell shows at the ports on the very next edge. It appears as out-of-order lanes, a lost or duplicated value, or a wrong extreme in lane 0 or lane 7. Many such faults show up only for particular orderings of the input. The bench therefore sweeps all 256 zero/one patterns, which cover every cell decision, before it applies random full-width words, repeated values and words differing only in the top bit. A fault in the register bank shows as a result that changes between edges or a non-zero value during reset.

// File: rtl/oem_sort_pkg.sv
package oem_sort_pkg;

    localparam int LANES  = 8;
    localparam int LEVELS = 6;

    // Partner lane of lane l at level s in the odd/even merge web, or -1
    // when the lane passes the level on a wire.
    function automatic int partner_of(input int s, input int l);
        int p;
        p = -1;
        case (s)
            0: p = l ^ 1;
            1: p = l ^ 2;
            2: begin
                if (l == 1) p = 2;
                if (l == 2) p = 1;
                if (l == 5) p = 6;
                if (l == 6) p = 5;
            end
            3: p = l ^ 4;
            4: begin
                if (l == 2) p = 4;
                if (l == 4) p = 2;
                if (l == 3) p = 5;
                if (l == 5) p = 3;
            end
            5: begin
                if (l == 1) p = 2;
                if (l == 2) p = 1;
                if (l == 3) p = 4;
                if (l == 4) p = 3;
                if (l == 5) p = 6;
                if (l == 6) p = 5;
            end
            default: p = -1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cex_cell.sv
module cex_cell #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] lo,
    output logic [WIDTH-1:0] hi
);
    logic swap;

    always_comb begin
        swap = (a > b);
        lo   = swap ? b : a;
        hi   = swap ? a : b;
    end
endmodule

// File: rtl/oem_level.sv
module oem_level
    import oem_sort_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int LEVEL = 0
) (
    input  logic [LANES*WIDTH-1:0] lvl_in,
    output logic [LANES*WIDTH-1:0] lvl_out
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int P = partner_of(LEVEL, l);
        if (P < 0) begin : g_wire
            assign lvl_out[l*WIDTH +: WIDTH] = lvl_in[l*WIDTH +: WIDTH];
        end else if (l < P) begin : g_cell
            cex_cell #(.WIDTH(WIDTH)) u_cex (
                .a  (lvl_in[l*WIDTH +: WIDTH]),
                .b  (lvl_in[P*WIDTH +: WIDTH]),
                .lo (lvl_out[l*WIDTH +: WIDTH]),
                .hi (lvl_out[P*WIDTH +: WIDTH])
            );
        end
    end
endmodule

// File: rtl/oem_sort8.sv
module oem_sort8
    import oem_sort_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter bit OUT_STAGE = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES*WIDTH-1:0] din,
    output logic [LANES*WIDTH-1:0] dout
);
    localparam int BUSW = LANES * WIDTH;

    logic [BUSW-1:0] web [LEVELS+1];

    assign web[0] = din;

    for (genvar s = 0; s < LEVELS; s++) begin : g_level
        oem_level #(.WIDTH(WIDTH), .LEVEL(s)) u_level (
            .lvl_in  (web[s]),
            .lvl_out (web[s+1])
        );
    end

    if (OUT_STAGE) begin : g_reg
        logic [BUSW-1:0] dout_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout_q <= '0;
            else        dout_q <= web[LEVELS];
        end
        assign dout = dout_q;
    end else begin : g_comb
        assign dout = rst_n ? web[LEVELS] : '0;
    end
endmodule

// File: rtl/oem_sort8_chk.sv
module oem_sort8_chk #(
    parameter int WIDTH     = 32,
    parameter int LANES     = 8,
    parameter bit OUT_STAGE = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES*WIDTH-1:0] din,
    input logic [LANES*WIDTH-1:0] dout
);
    localparam int SUMW = WIDTH + $clog2(LANES) + 1;

    logic            armed;
    logic [SUMW-1:0] sum_in, sum_out;
    logic [WIDTH-1:0] in_min, in_max;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    always_comb begin
        sum_in  = '0;
        sum_out = '0;
        in_min  = din[WIDTH-1:0];
        in_max  = din[WIDTH-1:0];
        for (int i = 0; i < LANES; i++) begin
            sum_in  = sum_in  + SUMW'(din[i*WIDTH +: WIDTH]);
            sum_out = sum_out + SUMW'(dout[i*WIDTH +: WIDTH]);
            if (din[i*WIDTH +: WIDTH] < in_min) in_min = din[i*WIDTH +: WIDTH];
            if (din[i*WIDTH +: WIDTH] > in_max) in_max = din[i*WIDTH +: WIDTH];
        end
    end

    for (genvar i = 0; i < LANES-1; i++) begin : g_ord
        assert_ordered_R1: assert property (@(posedge clk) disable iff (!rst_n)
            dout[i*WIDTH +: WIDTH] <= dout[(i+1)*WIDTH +: WIDTH]);
    end

    if (OUT_STAGE) begin : g_seq
        assert_sum_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> sum_out == $past(sum_in));
        assert_lane0_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> dout[WIDTH-1:0] == $past(in_min));
        assert_lane7_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> dout[(LANES-1)*WIDTH +: WIDTH] == $past(in_max));
        assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(armed) && $past(din) == $past(din, 2)) |-> $stable(dout));
    end
endmodule

bind oem_sort8 oem_sort8_chk #(
    .WIDTH     (WIDTH),
    .LANES     (8),
    .OUT_STAGE (OUT_STAGE)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .dout  (dout)
);

// File: tb/oem_sort8_tb.sv
module oem_sort8_tb;
    localparam int W = 32;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*W-1:0] din = '0;
    logic [N*W-1:0] dout;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    oem_sort8 #(.WIDTH(W), .OUT_STAGE(1'b1)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .dout  (dout)
    );

    always #2 clk = ~clk;

    function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
        logic [W-1:0] a [N];
        logic [W-1:0] t;
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
        for (int i = 1; i < N; i++) begin
            for (int j = i; j > 0; j--) begin
                if (a[j-1] > a[j]) begin
                    t = a[j]; a[j] = a[j-1]; a[j-1] = t;
                end
            end
        end
        for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [N*W-1:0] got, input logic [N*W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic apply(input string req, input logic [N*W-1:0] v);
        @(negedge clk);
        din = v;
        @(negedge clk);
        check(req, dout, ref_sort(v));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] v;
        logic [N*W-1:0] held;
        // R5: outputs zero while reset is held, even with non-zero input
        din = {N{32'hDEAD_BEEF}};
        repeat (3) @(negedge clk);
        check("R5 reset", dout, '0);
        rst_n = 1'b1;

        // R1/R2: every zero/one pattern
        for (int p = 0; p < 256; p++) begin
            v = '0;
            for (int i = 0; i < N; i++) v[i*W +: W] = W'(p[i]);
            apply("R1 R2 binary sweep", v);
        end

        // R3: top bit decides rank
        v = '0;
        v[0*W +: W] = 32'h8000_0000;
        v[1*W +: W] = 32'h7FFF_FFFF;
        v[2*W +: W] = 32'hFFFF_FFFF;
        v[3*W +: W] = 32'h0000_0001;
        v[4*W +: W] = 32'h8000_0001;
        v[5*W +: W] = 32'h0;
        v[6*W +: W] = 32'h7FFF_FFFE;
        v[7*W +: W] = 32'hC000_0000;
        apply("R3 unsigned", v);
        check("R3 top lane", {224'h0, dout[7*W +: W]}, {224'h0, 32'hFFFF_FFFF});

        // R6: already sorted input passes unchanged
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(i * 1000 + 7);
        apply("R6 presorted", v);
        check("R6 identity", dout, v);

        // R2: repeated values, reversed order
        for (int i = 0; i < N; i++) v[i*W +: W] = W'((N - 1 - i) / 2);
        apply("R2 duplicates", v);

        // R1/R2/R7: random words
        for (int k = 0; k < 600; k++) begin
            logic [W-1:0] mn, mx;
            for (int i = 0; i < N; i++) v[i*W +: W] = $urandom;
            mn = v[0 +: W];
            mx = v[0 +: W];
            for (int i = 1; i < N; i++) begin
                if (v[i*W +: W] < mn) mn = v[i*W +: W];
                if (v[i*W +: W] > mx) mx = v[i*W +: W];
            end
            apply("R1 R2 random", v);
            if (k < 20) begin
                check("R7 min", {224'h0, dout[0 +: W]}, {224'h0, mn});
                check("R7 max", {224'h0, dout[7*W +: W]}, {224'h0, mx});
            end
        end

        // R4: output holds between edges while input changes
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(50 - i * 3);
        apply("R4 load", v);
        held = dout;
        @(posedge clk);
        #1 din = {N{32'h1234_5678}};
        #1 check("R4 hold between edges", dout, held);
        @(negedge clk);
        check("R4 update after edge", dout, {N{32'h1234_5678}});

        // R5: reset asserted mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R5 async clear", dout, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 resume", dout, ref_sort(din));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule